// File: doc/BRIEF.md
# Routed Multi-Core Interrupt Vector Controller

The block gathers a large set of edge-triggered interrupt sources and turns them into level interrupt lines for a group of four cores. Each source has its own pending flag, its own enable bit and its own route byte. The route byte names the target cores as a bitmap and carries a destination node number. Every block of 32 vectors has a one-hot map that picks which of a core's output lines that block drives. An external function-level enable gates every output.

Software reaches the block through a plain 32-bit register bus with byte enables. Reads are combinational from the address. Writes take effect on the next clock edge. A handler reads a pending word and writes the same value back to acknowledge it. To move a vector to another core, software disables the vector, rewrites its route byte, and enables it again. The node number is stored and read back, but local delivery ignores it.

Top module: `vec_irq_router`

## Requirements
- R1: A 0-to-1 transition on `srcIn[v]`, seen between two consecutive clock edges, sets pending bit v. This happens whether or not the vector is enabled. A source held high does not set the bit again after it has been cleared.
- R2: Pending status reads at 0x1800 + 4*k. Bit j of word k is vector 32k+j, so each pair of words forms the 64-bit word v/64 with the low half at the lower address.
- R3: A write to a pending word clears every bit that is one in the byte-enabled write data. Zero bits have no effect. If a source edge lands in the same cycle as the clear of that bit, the bit stays set.
- R4: The enable bit of vector v is at address 0x1600 + 4*(v>>5), bit v&31. It is readable and writable with byte enables, and it resets to 0.
- R5: The route byte of vector v is byte lane v&3 of the word at 0x1C00 + (v & ~3). Bits 3:0 are the core bitmap (bit c = core c) and bits 7:4 are the node number. A write changes only the byte lanes whose enable is set.
- R6: Byte g&3 of the word at 0x14C0 + 4*(g>>2) is the line map for vector group g (vectors 32g..32g+31). Bit l selects core output line l.
- R7: `coreIrq[c*8+l]` is high one clock after some vector v is pending, enabled, has bit c of its route set, and has bit l set in its group's line map. The output is low one clock after no such vector remains.
- R8: While `ctrlEnable` is low, every `coreIrq` bit is low from the next clock on. Pending bits keep latching during this time.
- R9: The node field of a route byte has no effect on `coreIrq`.
- R10: The bounce words at 0x1680 + 4*k and the node-map words at 0x14A0 + 4*k read back what was written, and they do not affect `coreIrq`.
- R11: A retarget sequence of disable, route rewrite and re-enable on one vector leaves the route bytes and the delivered lines of every other vector unchanged.
- R12: An address outside all register ranges reads as 0, and a write to it changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlEnable | input | 1 | Function-level enable that gates all outputs |
| srcIn | input | 256 | Interrupt source levels, one per vector |
| busAddr | input | 13 | Register byte address |
| busWr | input | 1 | Write strobe |
| busByteEn | input | 4 | Write byte enables |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for `busAddr` (combinational) |
| coreIrq | output | 32 | Interrupt lines, core c line l at bit c*8+l |

## Verification
The bench builds the block with its default parameters: 256 vectors, four cores and eight lines per core. With these values all eight vector groups, all 64 route words and every core/line pair can be reached. Random route, enable, line-map and source traffic then exercises groups that share one line and vectors that target several cores at once. Directed cases cover the clear that collides with a source edge in the same cycle, partial byte-lane route writes and the retarget sequence.

// File: rtl/vir_pkg.sv
package vir_pkg;
  localparam int VEC_N      = 256;
  localparam int CORE_N     = 4;
  localparam int LINE_N     = 8;
  localparam int ADDR_W     = 13;
  localparam int GRP_SIZE   = 32;
  localparam int GROUP_N    = VEC_N / GRP_SIZE;
  localparam int ROUTE_WDS  = VEC_N / 4;
  localparam int LMAP_WDS   = (GROUP_N + 3) / 4;
  localparam int IDX_W      = $clog2(ROUTE_WDS);

  localparam int NODEMAP_BASE = 32'h14A0;
  localparam int LINEMAP_BASE = 32'h14C0;
  localparam int ENABLE_BASE  = 32'h1600;
  localparam int BOUNCE_BASE  = 32'h1680;
  localparam int PEND_BASE    = 32'h1800;
  localparam int ROUTE_BASE   = 32'h1C00;

  typedef enum logic [2:0] {
    RD_NONE, RD_NODEMAP, RD_LINEMAP, RD_ENABLE, RD_BOUNCE, RD_PEND, RD_ROUTE
  } rdSel_e;

  typedef struct packed {
    logic             wrNodeMap;
    logic             wrLineMap;
    logic             wrEnable;
    logic             wrBounce;
    logic             clrPend;
    logic             wrRoute;
    rdSel_e           rdSel;
    logic [IDX_W-1:0] idx;
    logic [3:0]       be;
    logic [31:0]      data;
  } regStrobe_t;
endpackage

// File: rtl/vir_ctrl.sv
module vir_ctrl
  import vir_pkg::*;
(
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic [3:0]        busByteEn,
  input  logic [31:0]       busWrData,
  output regStrobe_t        strb
);
  logic [31:0] addrW;
  assign addrW = 32'(busAddr);

  function automatic logic inRange(input logic [31:0] a, input int base, input int words);
    return (a >= 32'(base)) && (a < 32'(base + 4 * words));
  endfunction

  function automatic logic [IDX_W-1:0] idxOf(input logic [31:0] a, input int base);
    logic [31:0] off;
    off = a - 32'(base);
    return off[IDX_W+1:2];
  endfunction

  // Region decode: at most one region matches because the ranges are disjoint
  always_comb begin
    strb       = '0;
    strb.rdSel = RD_NONE;
    strb.be    = busByteEn;
    strb.data  = busWrData;
    if (inRange(addrW, NODEMAP_BASE, GROUP_N)) begin
      strb.rdSel     = RD_NODEMAP;
      strb.idx       = idxOf(addrW, NODEMAP_BASE);
      strb.wrNodeMap = busWr;
    end else if (inRange(addrW, LINEMAP_BASE, LMAP_WDS)) begin
      strb.rdSel     = RD_LINEMAP;
      strb.idx       = idxOf(addrW, LINEMAP_BASE);
      strb.wrLineMap = busWr;
    end else if (inRange(addrW, ENABLE_BASE, GROUP_N)) begin
      strb.rdSel    = RD_ENABLE;
      strb.idx      = idxOf(addrW, ENABLE_BASE);
      strb.wrEnable = busWr;
    end else if (inRange(addrW, BOUNCE_BASE, GROUP_N)) begin
      strb.rdSel    = RD_BOUNCE;
      strb.idx      = idxOf(addrW, BOUNCE_BASE);
      strb.wrBounce = busWr;
    end else if (inRange(addrW, PEND_BASE, GROUP_N)) begin
      strb.rdSel   = RD_PEND;
      strb.idx     = idxOf(addrW, PEND_BASE);
      strb.clrPend = busWr;
    end else if (inRange(addrW, ROUTE_BASE, ROUTE_WDS)) begin
      strb.rdSel   = RD_ROUTE;
      strb.idx     = idxOf(addrW, ROUTE_BASE);
      strb.wrRoute = busWr;
    end
  end
endmodule

// File: rtl/vir_datapath.sv
module vir_datapath
  import vir_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     ctrlEnable,
  input  logic [VEC_N-1:0]         srcIn,
  input  regStrobe_t               strb,
  output logic [31:0]              rdData,
  output logic [CORE_N*LINE_N-1:0] coreIrq
);
  logic [VEC_N-1:0]   enQ, bounceQ, pendQ, srcPrevQ, nodeMapQ;
  logic [VEC_N*8-1:0] routeQ;
  logic [7:0]         lineMapQ [GROUP_N];
  logic [VEC_N-1:0]   riseVec, clrMask, activeVec;
  logic [31:0]        beMask;
  logic [CORE_N*LINE_N-1:0] irqNext;

  assign beMask  = {{8{strb.be[3]}}, {8{strb.be[2]}}, {8{strb.be[1]}}, {8{strb.be[0]}}};
  assign riseVec = srcIn & ~srcPrevQ;

  function automatic logic [31:0] mergeWord(input logic [31:0] oldW, input logic [31:0] newW,
                                            input logic [31:0] mask);
    return (oldW & ~mask) | (newW & mask);
  endfunction

  always_comb begin
    clrMask = '0;
    for (int w = 0; w < GROUP_N; w++)
      if (strb.clrPend && strb.idx == IDX_W'(w))
        clrMask[w*32 +: 32] = strb.data & beMask;
  end

  // Word-wide registers: enable, bounce, node map, pending, source history
  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ      <= '0;
      bounceQ  <= '0;
      nodeMapQ <= '0;
      pendQ    <= '0;
      srcPrevQ <= '0;
    end else begin
      srcPrevQ <= srcIn;
      pendQ    <= (pendQ & ~clrMask) | riseVec;
      for (int w = 0; w < GROUP_N; w++) begin
        if (strb.wrEnable && strb.idx == IDX_W'(w))
          enQ[w*32 +: 32] <= mergeWord(enQ[w*32 +: 32], strb.data, beMask);
        if (strb.wrBounce && strb.idx == IDX_W'(w))
          bounceQ[w*32 +: 32] <= mergeWord(bounceQ[w*32 +: 32], strb.data, beMask);
        if (strb.wrNodeMap && strb.idx == IDX_W'(w))
          nodeMapQ[w*32 +: 32] <= mergeWord(nodeMapQ[w*32 +: 32], strb.data, beMask);
      end
    end
  end

  // Byte-wide registers: route bytes and line maps
  always_ff @(posedge clk) begin
    if (!rstN) begin
      routeQ <= '0;
      for (int g = 0; g < GROUP_N; g++) lineMapQ[g] <= '0;
    end else begin
      for (int v = 0; v < VEC_N; v++)
        if (strb.wrRoute && strb.idx == IDX_W'(v / 4) && strb.be[v % 4])
          routeQ[v*8 +: 8] <= strb.data[(v % 4)*8 +: 8];
      for (int g = 0; g < GROUP_N; g++)
        if (strb.wrLineMap && strb.idx == IDX_W'(g / 4) && strb.be[g % 4])
          lineMapQ[g] <= strb.data[(g % 4)*8 +: 8];
    end
  end

  // Read mux
  always_comb begin
    rdData = '0;
    unique case (strb.rdSel)
      RD_NODEMAP: for (int w = 0; w < GROUP_N; w++)
                    if (strb.idx == IDX_W'(w)) rdData = nodeMapQ[w*32 +: 32];
      RD_ENABLE:  for (int w = 0; w < GROUP_N; w++)
                    if (strb.idx == IDX_W'(w)) rdData = enQ[w*32 +: 32];
      RD_BOUNCE:  for (int w = 0; w < GROUP_N; w++)
                    if (strb.idx == IDX_W'(w)) rdData = bounceQ[w*32 +: 32];
      RD_PEND:    for (int w = 0; w < GROUP_N; w++)
                    if (strb.idx == IDX_W'(w)) rdData = pendQ[w*32 +: 32];
      RD_LINEMAP: for (int g = 0; g < GROUP_N; g++)
                    if (strb.idx == IDX_W'(g / 4)) rdData[(g % 4)*8 +: 8] = lineMapQ[g];
      RD_ROUTE:   for (int v = 0; v < VEC_N; v++)
                    if (strb.idx == IDX_W'(v / 4)) rdData[(v % 4)*8 +: 8] = routeQ[v*8 +: 8];
      default:    rdData = '0;
    endcase
  end

  // Delivery: per group and core, any active vector routed there
  assign activeVec = pendQ & enQ;

  logic [CORE_N-1:0] grpHit [GROUP_N];
  logic [VEC_N-1:0]  coreSel [CORE_N];

  for (genvar c = 0; c < CORE_N; c++) begin : g_coreSel
    for (genvar v = 0; v < VEC_N; v++) begin : g_vec
      assign coreSel[c][v] = routeQ[v*8 + c];
    end
  end

  for (genvar g = 0; g < GROUP_N; g++) begin : g_grp
    for (genvar c = 0; c < CORE_N; c++) begin : g_core
      assign grpHit[g][c] = |(activeVec[g*GRP_SIZE +: GRP_SIZE] & coreSel[c][g*GRP_SIZE +: GRP_SIZE]);
    end
  end

  always_comb begin
    irqNext = '0;
    for (int c = 0; c < CORE_N; c++)
      for (int l = 0; l < LINE_N; l++)
        for (int g = 0; g < GROUP_N; g++)
          if (grpHit[g][c] && lineMapQ[g][l]) irqNext[c*LINE_N + l] = 1'b1;
    if (!ctrlEnable) irqNext = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) coreIrq <= '0;
    else       coreIrq <= irqNext;
  end

  // R8
  gate_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlEnable |=> (coreIrq == '0));

  // R1
  pend_src_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((pendQ & ~$past(pendQ) & ~$past(riseVec)) == '0));

  // R3
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrPend |=> ((pendQ & $past(clrMask) & ~$past(riseVec)) == '0));

  // R4
  en_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrEnable |=> $stable(enQ));

  // R5
  route_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrRoute |=> $stable(routeQ));

  // R7
  irq_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|coreIrq) |-> $past(|activeVec));
endmodule

// File: rtl/vec_irq_router.sv
module vec_irq_router
  import vir_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     ctrlEnable,
  input  logic [VEC_N-1:0]         srcIn,
  input  logic [ADDR_W-1:0]        busAddr,
  input  logic                     busWr,
  input  logic [3:0]               busByteEn,
  input  logic [31:0]              busWrData,
  output logic [31:0]              busRdData,
  output logic [CORE_N*LINE_N-1:0] coreIrq
);
  regStrobe_t strb;

  vir_ctrl ctrl_i (
    .busAddr   (busAddr),
    .busWr     (busWr),
    .busByteEn (busByteEn),
    .busWrData (busWrData),
    .strb      (strb)
  );

  vir_datapath dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .ctrlEnable (ctrlEnable),
    .srcIn      (srcIn),
    .strb       (strb),
    .rdData     (busRdData),
    .coreIrq    (coreIrq)
  );
endmodule

// File: tb/vec_irq_router_tb_top.sv
`timescale 1ns/1ps
module vec_irq_router_tb_top;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         ctrlEnable = 1'b0;
  logic [255:0] srcIn = '0;
  logic [12:0]  busAddr = '0;
  logic         busWr = 1'b0;
  logic [3:0]   busByteEn = '0;
  logic [31:0]  busWrData = '0;
  logic [31:0]  busRdData;
  logic [31:0]  coreIrq;

  always #2 clk = ~clk;

  vec_irq_router dut_i (
    .clk(clk), .rstN(rstN), .ctrlEnable(ctrlEnable), .srcIn(srcIn),
    .busAddr(busAddr), .busWr(busWr), .busByteEn(busByteEn),
    .busWrData(busWrData), .busRdData(busRdData), .coreIrq(coreIrq)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  bit [255:0] mEn, mPend, mBounce, mNode, mSrc;
  bit [7:0]   mRoute [256];
  bit [7:0]   mLine  [8];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit [31:0] expIrq();
    bit [31:0] r = '0;
    if (!ctrlEnable) return '0;
    for (int v = 0; v < 256; v++)
      if (mPend[v] && mEn[v])
        for (int c = 0; c < 4; c++)
          if (mRoute[v][c])
            for (int l = 0; l < 8; l++)
              if (mLine[v/32][l]) r[c*8+l] = 1'b1;
    return r;
  endfunction

  function automatic bit [31:0] expRead(input int a);
    bit [31:0] r = '0;
    if (a >= 'h14A0 && a < 'h14C0) r = mNode[((a-'h14A0)/4)*32 +: 32];
    else if (a >= 'h14C0 && a < 'h14C8)
      for (int b = 0; b < 4; b++) r[b*8 +: 8] = mLine[((a-'h14C0)/4)*4 + b];
    else if (a >= 'h1600 && a < 'h1620) r = mEn[((a-'h1600)/4)*32 +: 32];
    else if (a >= 'h1680 && a < 'h16A0) r = mBounce[((a-'h1680)/4)*32 +: 32];
    else if (a >= 'h1800 && a < 'h1820) r = mPend[((a-'h1800)/4)*32 +: 32];
    else if (a >= 'h1C00 && a < 'h1D00)
      for (int b = 0; b < 4; b++) r[b*8 +: 8] = mRoute[((a-'h1C00)/4)*4 + b];
    return r;
  endfunction

  function automatic void modelWrite(input int a, input bit [31:0] d, input bit [3:0] be);
    bit [31:0] m;
    for (int b = 0; b < 4; b++) m[b*8 +: 8] = {8{be[b]}};
    if (a >= 'h14A0 && a < 'h14C0) begin
      int w = (a-'h14A0)/4; mNode[w*32 +: 32] = (mNode[w*32 +: 32] & ~m) | (d & m);
    end else if (a >= 'h14C0 && a < 'h14C8) begin
      for (int b = 0; b < 4; b++) if (be[b]) mLine[((a-'h14C0)/4)*4 + b] = d[b*8 +: 8];
    end else if (a >= 'h1600 && a < 'h1620) begin
      int w = (a-'h1600)/4; mEn[w*32 +: 32] = (mEn[w*32 +: 32] & ~m) | (d & m);
    end else if (a >= 'h1680 && a < 'h16A0) begin
      int w = (a-'h1680)/4; mBounce[w*32 +: 32] = (mBounce[w*32 +: 32] & ~m) | (d & m);
    end else if (a >= 'h1800 && a < 'h1820) begin
      int w = (a-'h1800)/4; mPend[w*32 +: 32] = mPend[w*32 +: 32] & ~(d & m);
    end else if (a >= 'h1C00 && a < 'h1D00) begin
      for (int b = 0; b < 4; b++) if (be[b]) mRoute[((a-'h1C00)/4)*4 + b] = d[b*8 +: 8];
    end
  endfunction

  // Called at a negedge; returns at the negedge after the write edge
  task automatic busWrite(input int a, input bit [31:0] d, input bit [3:0] be);
    busAddr = 13'(a); busWrData = d; busByteEn = be; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
    modelWrite(a, d, be);
  endtask

  task automatic readChk(input int a, input string req);
    busAddr = 13'(a);
    #0.5;
    chk(busRdData === expRead(a), req, busRdData, expRead(a));
  endtask

  task automatic setSrc(input bit [255:0] val);
    srcIn = val;
    mPend |= val & ~mSrc;
    mSrc = val;
    @(negedge clk);
  endtask

  task automatic irqChk(input string req);
    @(negedge clk);
    chk(coreIrq === expIrq(), req, coreIrq, expIrq());
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog R1..R12 run actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    bit [255:0] s;
    void'($urandom(32'd20240611));
    for (int v = 0; v < 256; v++) mRoute[v] = '0;
    for (int g = 0; g < 8; g++) mLine[g] = '0;
    mEn = '0; mPend = '0; mBounce = '0; mNode = '0; mSrc = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // Reset state
    chk(coreIrq === '0, "R7 reset", coreIrq, '0);
    readChk('h1604, "R4 reset enable");
    readChk('h1800, "R2 reset pending");
    readChk('h1C28, "R5 reset route");

    ctrlEnable = 1'b1;
    // R6: group g -> line g
    busWrite('h14C0, 32'h08040201, 4'hF);
    busWrite('h14C4, 32'h80402010, 4'hF);
    readChk('h14C4, "R6 line map readback");

    // R1: edge while disabled latches pending, no output
    s = mSrc; s[40] = 1'b1; setSrc(s);
    readChk('h1804, "R2 R1 pending word1 bit8");
    irqChk("R1 disabled vector silent");
    // R5: route vector 40 to core 2, node 5, lane 0 only
    busWrite('h1C28, 32'hFFFFFF54, 4'h1);
    readChk('h1C28, "R5 lane0 write");
    busWrite('h1604, 32'h0000_0100, 4'hF);
    irqChk("R7 core2 line1");
    chk(coreIrq === 32'h0002_0000, "R7 bit17", coreIrq, 32'h0002_0000);

    // R9: change node only
    busWrite('h1C28, 32'h0000_00A4, 4'h1);
    irqChk("R9 node field no effect");

    // R8
    ctrlEnable = 1'b0;
    s = mSrc; s[200] = 1'b1; setSrc(s);
    chk(coreIrq === '0, "R8 gated", coreIrq, '0);
    readChk('h1818, "R8 pending latches while gated");
    ctrlEnable = 1'b1;
    irqChk("R8 ungated");

    // R3: zero write no effect, then clear
    busWrite('h1804, 32'h0, 4'hF);
    readChk('h1804, "R3 zero write");
    busWrite('h1804, 32'h0000_0100, 4'hF);
    readChk('h1804, "R3 cleared");
    irqChk("R3 R1 held level no re-set");

    // R3: edge and clear collide
    busAddr = 13'h1800; busWrData = 32'h8; busByteEn = 4'hF; busWr = 1'b1;
    srcIn[3] = 1'b1; mSrc[3] = 1'b1; mPend[3] = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
    readChk('h1800, "R3 edge wins over clear");

    // R11: retarget vector 41 while 40 stays delivered
    s = mSrc; s[40] = 1'b0; s[41] = 1'b0; setSrc(s);
    s[40] = 1'b1; s[41] = 1'b1; setSrc(s);
    busWrite('h1C28, 32'h0000_0100, 4'h2); // 41 -> core0
    busWrite('h1604, 32'h0000_0300, 4'hF);
    irqChk("R11 both delivered");
    busWrite('h1604, 32'h0000_0100, 4'hF);
    busWrite('h1C28, 32'h0000_0800, 4'h2); // 41 -> core3
    busWrite('h1604, 32'h0000_0300, 4'hF);
    irqChk("R11 retarget");
    readChk('h1C28, "R11 neighbour route intact");

    // R5: middle lane only
    busWrite('h1C28, 32'h1234_5678, 4'h4);
    readChk('h1C28, "R5 lane2 only");

    // R10: bounce and node map
    busWrite('h1684, 32'hDEAD_BEEF, 4'hF);
    busWrite('h14A8, 32'hCAFE_F00D, 4'h3);
    readChk('h1684, "R10 bounce readback");
    readChk('h14A8, "R10 node map readback");
    irqChk("R10 no delivery effect");

    // R12: unmapped address
    busWrite('h1000, 32'hFFFF_FFFF, 4'hF);
    readChk('h1000, "R12 unmapped reads zero");
    irqChk("R12 unmapped write ignored");

    // R6: move group 1 to line 2
    busWrite('h14C0, 32'h0000_0400, 4'h2);
    irqChk("R6 line move");

    // Random traffic
    for (int it = 0; it < 600; it++) begin
      int op = int'($urandom % 7);
      case (op)
        0: busWrite('h1C00 + 4*int'($urandom % 64), $urandom, 4'($urandom));
        1: busWrite('h1600 + 4*int'($urandom % 8), $urandom, 4'($urandom));
        2: begin
          s = mSrc;
          for (int w = 0; w < 8; w++) s[w*32 +: 32] ^= ($urandom & $urandom & $urandom);
          setSrc(s);
        end
        3: begin
          int w = int'($urandom % 8);
          busWrite('h1800 + 4*w, mPend[w*32 +: 32] & $urandom, 4'hF);
        end
        4: begin
          int w = int'($urandom % 2);
          bit [31:0] d;
          for (int b = 0; b < 4; b++) d[b*8 +: 8] = 8'(1 << ($urandom % 8));
          busWrite('h14C0 + 4*w, d, 4'($urandom));
        end
        5: begin
          int bases [6] = '{'h14A0, 'h14C0, 'h1600, 'h1680, 'h1800, 'h1C00};
          int k = int'($urandom % 6);
          readChk(bases[k] + 4*int'($urandom % 2), "R2 R4 R5 R6 R10 random readback");
        end
        default: ctrlEnable = ($urandom % 4) != 0;
      endcase
      irqChk("R7 random delivery");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule